// File: doc/BRIEF.md
# Eight-Input Interrupt Controller

This block collects requests on eight interrupt lines and raises one interrupt output to a processor. Each line is latched in a request register, which is edge or level triggered as configured. An eight-bit mask register removes lines from arbitration. An in-service register records which interrupts the processor is handling now. A fixed-priority resolver picks the winning request. A request only interrupts the processor when it outranks everything already in service, so handlers nest in priority order.

The processor acknowledges an interrupt with two one-cycle strobes on `ack`. The first strobe moves the winning request into service. The second strobe returns a vector byte, made of a programmable base and the line number. A service period ends in one of two ways: the processor writes an end-of-interrupt command, either non-specific or naming a level, or the block clears the in-service bit by itself on the second strobe. As an alternative to the interrupt output, the processor can poll. It arms a poll with a command, and the next read returns a word naming the highest pending line. That read also counts as an acknowledge.

Writes with `wr_sel`=0 are commands, decoded from `wr_data[7:6]`. Writes with `wr_sel`=1 load the mask.

| `wr_data[7:6]` | Command | Fields |
|---|---|---|
| 00 | configuration | bit0 = 1 selects level trigger, 0 selects edge trigger; bit1 enables automatic end-of-interrupt; bit2 enables poll mode |
| 01 | vector base | bits 4:0 become vector bits 7:3 |
| 10 | end-of-interrupt | bit5 = 1 for the specific form; bits 2:0 give the level |
| 11 | read control | bit0 = 1 reads the in-service register, 0 reads the request register; bit2 = 1 arms a poll |

Reads with `rd_sel`=1 return the mask. Reads with `rd_sel`=0 return the poll word if a poll is armed, and otherwise the register chosen by read control. `rd_data` is combinational while `rd_en` is high, and 0 otherwise.

Top module: `pic8_irq_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are 0, and `int_out` is low. The block is in edge trigger mode with normal end-of-interrupt and poll mode off. Read control selects the request register, and the vector base is 0.
- R2: Line 0 has the highest priority and line 7 the lowest. One cycle after the second `ack` strobe, `vec_valid` is high for exactly one cycle, and `vec_data` equals base*8 + the line captured at the first strobe.
- R3: `int_out` is high exactly when an unmasked pending request has a lower line number than every set in-service bit and poll mode is off.
- R4: The first `ack` strobe sets the in-service bit of the winning line. In edge mode it also clears that line's request bit.
- R5: With automatic end-of-interrupt off, an in-service bit stays set until an end-of-interrupt command clears it. The non-specific command (bit5=0) clears the lowest-numbered set in-service bit.
- R6: The specific end-of-interrupt command (bit5=1) clears the in-service bit named by `wr_data[2:0]`, whatever its rank.
- R7: With automatic end-of-interrupt on (config bit1=1), the second `ack` strobe clears the in-service bit set by the first strobe.
- R8: In edge mode (config bit0=0), a request bit is set one cycle after a low-to-high change of its line, and stays set after the line falls. In level mode (config bit0=1), the request register copies the lines with one cycle of delay.
- R9: If no unmasked request wins at the first `ack` strobe, the captured line is 7 and no in-service bit is set. This covers a level request that has already dropped.
- R10: A line whose mask bit is 1 does not take part in arbitration, but its request bit still latches and can be read.
- R11: In poll mode (config bit2=1), `int_out` stays low. After a read-control write with bit2=1, the next read with `rd_sel`=0 returns {any pending winner, 0000, winner line}. If there is a winner, that read sets its in-service bit as an acknowledge does.
- R12: Read control bit0 selects whether a `rd_sel`=0 read returns the request register (0) or the in-service register (1). A `rd_sel`=1 read returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, bit n is line n |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = command write, 1 = mask write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = status or poll word, 1 = mask |
| rd_data | output | 8 | Read data, combinational while `rd_en` is high |
| ack | input | 1 | Acknowledge strobe; strobes alternate between first and second |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle pulse after the second acknowledge |
| vec_data | output | 8 | Vector byte |

## Verification
A stale in-service bit shows up at once as a wrong `int_out` level: either a lower-priority request is blocked, or a lower line interrupts while a higher one is still in service. A wrong request bit shows up as a wrong vector on the very next acknowledge pair, or as a wrong value on the next status read. The bench's model predicts `int_out`, `rd_data` and the vector outputs in every cycle, so a corrupted register is caught within the cycle in which it first affects a port. Directed sequences cover nesting, both end-of-interrupt forms, masking, a dropped level request and polling. A randomised stretch then mixes line activity, commands and acknowledge strobes.

// File: rtl/pic8_pkg.sv
`timescale 1ns/1ps
// pic8_pkg: shared command encodings and configuration record of the
// eight-input interrupt controller.
package pic8_pkg;

    // Command kind carried in the top two bits of a command write.
    typedef enum logic [1:0] {
        CMD_CFG   = 2'b00,
        CMD_BASE  = 2'b01,
        CMD_EOI   = 2'b10,
        CMD_RDCTL = 2'b11
    } cmd_kind_e;

    // Operating configuration written by CMD_CFG.
    typedef struct packed {
        logic poll_mode;
        logic auto_eoi;
        logic level_trig;
    } cfg_t;

endpackage

// File: rtl/pic8_req_latch.sv
`timescale 1ns/1ps
// pic8_req_latch: request register.
// In edge mode each bit sets on a rising edge of its line and clears on
// clr_mask. In level mode the register copies the lines every cycle.
// Assumes the lines are already synchronous to clk.
module pic8_req_latch #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_mode,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] clr_mask,
    output logic [N_LINES-1:0] irr
);

    logic [N_LINES-1:0] prev_q;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            // Per-line request bit: level copy or edge latch.
            always_ff @(posedge clk) begin
                if (!rst_n)          irr[g] <= 1'b0;
                else if (level_mode) irr[g] <= irq_in[g];
                else                 irr[g] <= (irr[g] & ~clr_mask[g]) | (irq_in[g] & ~prev_q[g]);
            end

            // R8: in edge mode a new request bit needs a rising edge on its line.
            p_edge_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!level_mode && $past(!level_mode) && $past(rst_n) && irr[g] && !$past(irr[g]))
                    |-> $past(irq_in[g] && !prev_q[g]));
        end
    endgenerate

endmodule

// File: rtl/pic8_prio.sv
`timescale 1ns/1ps
// pic8_prio: fixed-priority resolver. Line 0 ranks highest.
// Finds the best pending request and the best in-service level. The request
// wins only if it outranks every in-service bit. Purely combinational.
module pic8_prio #(
    parameter int N_LINES = 8,
    parameter int LVL_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] pend,
    input  logic [N_LINES-1:0] isr,
    output logic               win_valid,
    output logic [LVL_W-1:0]   win_lvl,
    output logic               top_valid,
    output logic [LVL_W-1:0]   top_lvl
);

    logic             raw_valid;
    logic [LVL_W-1:0] raw_lvl;

    // Lowest-numbered pending request.
    always_comb begin
        raw_valid = 1'b0;
        raw_lvl   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                raw_valid = 1'b1;
                raw_lvl   = LVL_W'(i);
            end
        end
    end

    // Lowest-numbered in-service level.
    always_comb begin
        top_valid = 1'b0;
        top_lvl   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (isr[i]) begin
                top_valid = 1'b1;
                top_lvl   = LVL_W'(i);
            end
        end
    end

    // Nesting rule: the request must outrank all service in progress.
    always_comb begin
        win_valid = raw_valid && (!top_valid || (raw_lvl < top_lvl));
        win_lvl   = raw_lvl;
    end

endmodule

// File: rtl/pic8_svc.sv
`timescale 1ns/1ps
// pic8_svc: in-service register with end-of-interrupt handling.
// A set from an acknowledge takes precedence over a clear of the same bit in
// the same cycle. The non-specific form clears the level given by top_lvl.
module pic8_svc #(
    parameter int N_LINES = 8,
    parameter int LVL_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [LVL_W-1:0]   set_lvl,
    input  logic               eoi_en,
    input  logic               eoi_specific,
    input  logic [LVL_W-1:0]   eoi_lvl,
    input  logic               top_valid,
    input  logic [LVL_W-1:0]   top_lvl,
    input  logic               auto_en,
    input  logic [LVL_W-1:0]   auto_lvl,
    output logic [N_LINES-1:0] isr
);

    logic [N_LINES-1:0] set_vec;
    logic [N_LINES-1:0] clr_vec;

    // Decode the set and clear sources into one-hot vectors.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_en) set_vec[set_lvl] = 1'b1;
        if (eoi_en) begin
            if (eoi_specific)   clr_vec[eoi_lvl] = 1'b1;
            else if (top_valid) clr_vec[top_lvl] = 1'b1;
        end
        if (auto_en) clr_vec[auto_lvl] = 1'b1;
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~clr_vec) | set_vec;
    end

    // R6: the specific command clears the named level.
    p_eoi_specific_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && eoi_specific && !(set_en && set_lvl == eoi_lvl)) |=> !isr[$past(eoi_lvl)]);

    // R5: the non-specific command clears the top in-service level.
    p_eoi_nonspec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && !eoi_specific && top_valid && !(set_en && set_lvl == top_lvl)) |=> !isr[$past(top_lvl)]);

endmodule

// File: rtl/pic8_irq_ctrl.sv
`timescale 1ns/1ps
// pic8_irq_ctrl: eight-input interrupt controller, top level.
// Decodes commands, runs the two-strobe acknowledge sequence, and forms
// the interrupt output and read data. Assumes acknowledge strobes are single
// cycles and alternate first/second, and that all inputs are synchronous.
module pic8_irq_ctrl
    import pic8_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ack,
    output logic               int_out,
    output logic               vec_valid,
    output logic [DATA_W-1:0]  vec_data
);

    localparam int LVL_W  = $clog2(N_LINES);
    localparam int BASE_W = DATA_W - LVL_W;
    localparam int PAD_W  = DATA_W - 1 - LVL_W;

    cfg_t               cfg_q;
    logic [BASE_W-1:0]  base_q;
    logic [N_LINES-1:0] imr_q;
    logic               rd_isr_q;
    logic               poll_armed_q;
    logic               ack_phase_q;
    logic [LVL_W-1:0]   cap_lvl_q;
    logic               cap_hit_q;

    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] isr;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] irr_clr;
    logic               win_valid;
    logic [LVL_W-1:0]   win_lvl;
    logic               top_valid;
    logic [LVL_W-1:0]   top_lvl;

    cmd_kind_e          cmd_kind;
    logic               cmd_wr;
    logic               eoi_wr;
    logic               first_ack;
    logic               second_ack;
    logic               poll_rd;
    logic               take;
    logic               auto_clr;

    // Strobe and command decode.
    always_comb begin
        cmd_kind   = cmd_kind_e'(wr_data[DATA_W-1 -: 2]);
        cmd_wr     = wr_en && !wr_sel;
        eoi_wr     = cmd_wr && (cmd_kind == CMD_EOI);
        first_ack  = ack && !ack_phase_q;
        second_ack = ack && ack_phase_q;
        poll_rd    = rd_en && !rd_sel && poll_armed_q;
        take       = (first_ack || poll_rd) && win_valid;
        auto_clr   = second_ack && cfg_q.auto_eoi && cap_hit_q;
        pend       = irr & ~imr_q;
        irr_clr    = '0;
        if (take) irr_clr[win_lvl] = 1'b1;
    end

    pic8_req_latch #(.N_LINES(N_LINES)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (cfg_q.level_trig),
        .irq_in     (irq_in),
        .clr_mask   (irr_clr),
        .irr        (irr)
    );

    pic8_prio #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_prio (
        .pend      (pend),
        .isr       (isr),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .top_valid (top_valid),
        .top_lvl   (top_lvl)
    );

    pic8_svc #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_svc (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en       (take),
        .set_lvl      (win_lvl),
        .eoi_en       (eoi_wr),
        .eoi_specific (wr_data[5]),
        .eoi_lvl      (wr_data[LVL_W-1:0]),
        .top_valid    (top_valid),
        .top_lvl      (top_lvl),
        .auto_en      (auto_clr),
        .auto_lvl     (cap_lvl_q),
        .isr          (isr)
    );

    // Configuration, vector base, mask and read-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            base_q   <= '0;
            imr_q    <= '0;
            rd_isr_q <= 1'b0;
        end else if (wr_en && wr_sel) begin
            imr_q <= wr_data[N_LINES-1:0];
        end else if (cmd_wr) begin
            case (cmd_kind)
                CMD_CFG:   cfg_q    <= cfg_t'(wr_data[2:0]);
                CMD_BASE:  base_q   <= wr_data[BASE_W-1:0];
                CMD_RDCTL: rd_isr_q <= wr_data[0];
                default:   ;
            endcase
        end
    end

    // Poll request: armed by a command, consumed by the next status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          poll_armed_q <= 1'b0;
        else if (cmd_wr && cmd_kind == CMD_RDCTL && wr_data[2]) poll_armed_q <= 1'b1;
        else if (poll_rd)                                    poll_armed_q <= 1'b0;
    end

    // Acknowledge sequence: capture on the first strobe, emit on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_phase_q <= 1'b0;
            cap_lvl_q   <= '0;
            cap_hit_q   <= 1'b0;
            vec_valid   <= 1'b0;
            vec_data    <= '0;
        end else begin
            vec_valid <= second_ack;
            if (first_ack) begin
                ack_phase_q <= 1'b1;
                cap_hit_q   <= win_valid;
                cap_lvl_q   <= win_valid ? win_lvl : LVL_W'(N_LINES - 1);
            end else if (second_ack) begin
                ack_phase_q <= 1'b0;
                vec_data    <= {base_q, cap_lvl_q};
            end
        end
    end

    // Interrupt output and read data.
    always_comb begin
        int_out = win_valid && !cfg_q.poll_mode;
        if (!rd_en)            rd_data = '0;
        else if (rd_sel)       rd_data = DATA_W'(imr_q);
        else if (poll_armed_q) rd_data = {win_valid, {PAD_W{1'b0}}, win_lvl};
        else if (rd_isr_q)     rd_data = DATA_W'(isr);
        else                   rd_data = DATA_W'(irr);
    end

    // R11: poll mode keeps the interrupt output quiet.
    p_poll_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.poll_mode |-> !int_out);

    // R4: the first strobe puts the winner in service.
    p_ack_sets_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ack && win_valid) |=> isr[$past(win_lvl)]);

    // R7: automatic end-of-interrupt clears the captured level.
    p_auto_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_clr |=> !isr[$past(cap_lvl_q)]);

    // R2: the vector strobe lasts one cycle.
    p_vec_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R10: with every line masked no interrupt is raised.
    p_mask_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&imr_q) |-> !int_out);

    // R9: a strobe with no winner sets no in-service bit.
    p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ack && !win_valid && !poll_rd && !eoi_wr) |=> (isr == $past(isr)));

endmodule

// File: tb/tb_pic8_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model stepped every clock and compared
// with the outputs, then directed corner cases and a randomised stretch.
module tb_pic8_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0, ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, vec_data;
    logic       int_out, vec_valid;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    // Reference model state.
    logic [7:0] m_irr, m_prev, m_isr, m_imr, m_vd;
    logic [4:0] m_base;
    logic       m_level, m_aeoi, m_poll, m_rdisr, m_armed, m_phase, m_hit, m_vv;
    int         m_cap;

    always #2 clk = ~clk;

    pic8_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .ack(ack), .int_out(int_out), .vec_valid(vec_valid), .vec_data(vec_data)
    );

    // Index of the lowest set bit, or -1 if none.
    function automatic int low_bit(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Winning line under the nesting rule, or -1.
    function automatic int m_winner();
        int p = low_bit(m_irr & ~m_imr);
        int t = low_bit(m_isr);
        if (p < 0) return -1;
        if (t >= 0 && p >= t) return -1;
        return p;
    endfunction

    function automatic logic [7:0] m_rd_exp();
        int w = m_winner();
        if (!rd_en) return 8'h00;
        if (rd_sel) return m_imr;
        if (m_armed) return (w >= 0) ? (8'h80 | 8'(w)) : 8'h00;
        return m_rdisr ? m_isr : m_irr;
    endfunction

    task automatic m_reset();
        m_irr = '0; m_prev = '0; m_isr = '0; m_imr = '0; m_vd = '0; m_base = '0;
        m_level = 0; m_aeoi = 0; m_poll = 0; m_rdisr = 0; m_armed = 0;
        m_phase = 0; m_hit = 0; m_vv = 0; m_cap = 0;
    endtask

    // Advance the model by one clock using the current inputs.
    task automatic m_step();
        int         w = m_winner();
        int         t = low_bit(m_isr);
        logic       first = ack && !m_phase;
        logic       second = ack && m_phase;
        logic       pollrd = rd_en && !rd_sel && m_armed;
        logic       cmdw = wr_en && !wr_sel;
        logic [7:0] setv = '0, clrv = '0, irrclr = '0;
        if (!rst_n) begin m_reset(); return; end
        if ((first || pollrd) && w >= 0) begin setv[w] = 1; irrclr[w] = 1; end
        if (cmdw && wr_data[7:6] == 2'b10) begin
            if (wr_data[5]) clrv[wr_data[2:0]] = 1;
            else if (t >= 0) clrv[t] = 1;
        end
        if (second && m_aeoi && m_hit) clrv[m_cap] = 1;
        m_vv = second;
        if (second) m_vd = {m_base, 3'(m_cap)};
        if (first) begin m_hit = (w >= 0); m_cap = (w >= 0) ? w : 7; end
        if (ack) m_phase = !m_phase;
        if (m_level) m_irr = irq_in;
        else         m_irr = (m_irr & ~irrclr) | (irq_in & ~m_prev);
        m_prev = irq_in;
        m_isr = (m_isr & ~clrv) | setv;
        if (cmdw && wr_data[7:6] == 2'b11 && wr_data[2]) m_armed = 1;
        else if (pollrd) m_armed = 0;
        if (wr_en && wr_sel) m_imr = wr_data;
        else if (cmdw) begin
            case (wr_data[7:6])
                2'b00: begin m_level = wr_data[0]; m_aeoi = wr_data[1]; m_poll = wr_data[2]; end
                2'b01: m_base = wr_data[4:0];
                2'b11: m_rdisr = wr_data[0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Compare every output with the model, then step one clock.
    task automatic tick();
        #1;
        chk((cur_tag == "R2") ? "R2" : {cur_tag, "/R3"}, "int_out", {7'b0, int_out},
            {7'b0, (m_winner() >= 0) && !m_poll});
        chk({cur_tag, "/R12"}, "rd_data", rd_data, m_rd_exp());
        chk({cur_tag, "/R2"}, "vec_valid", {7'b0, vec_valid}, {7'b0, m_vv});
        chk({cur_tag, "/R2"}, "vec_data", vec_data, m_vd);
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic rd_expect(logic sel, string tag, logic [7:0] exp);
        rd_en = 1; rd_sel = sel;
        #0.5 chk(tag, "read", rd_data, exp);
        tick();
        rd_en = 0;
    endtask

    task automatic int_expect(string tag, logic exp);
        #0.5 chk(tag, "int_out", {7'b0, int_out}, {7'b0, exp});
    endtask

    // Two acknowledge strobes, then check the vector.
    task automatic ack_pair(string tag, logic [7:0] exp);
        ack = 1; tick(); ack = 0; tick(); ack = 1; tick(); ack = 0;
        #0.5;
        chk(tag, "vec_valid", {7'b0, vec_valid}, 8'h01);
        chk(tag, "vec_data", vec_data, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        tick();
        rst_n = 1;
        // R1: reset state
        cur_tag = "R1";
        tick();
        int_expect("R1", 1'b0);
        rd_expect(0, "R1", 8'h00);
        rd_expect(1, "R1", 8'h00);
        wr(0, 8'hC1);
        rd_expect(0, "R1", 8'h00);
        wr(0, 8'hC0);

        // R2/R4/R5: basic service with vector base 0x20
        cur_tag = "R2";
        wr(0, 8'h44);
        irq_in = 8'h08; tick(); tick();
        int_expect("R8", 1'b1);
        ack_pair("R2", 8'h23);
        cur_tag = "R4";
        wr(0, 8'hC1);
        rd_expect(0, "R4", 8'h08);
        wr(0, 8'hC0);
        rd_expect(0, "R4", 8'h00);
        cur_tag = "R5";
        wr(0, 8'h80);
        wr(0, 8'hC1);
        rd_expect(0, "R5", 8'h00);

        // R3: nesting by priority
        cur_tag = "R3";
        irq_in = 8'h24; tick(); tick();
        ack_pair("R2", 8'h22);
        tick();
        int_expect("R3", 1'b0);
        irq_in = 8'h26; tick(); tick();
        int_expect("R3", 1'b1);
        ack_pair("R3", 8'h21);
        rd_expect(0, "R3", 8'h06);
        cur_tag = "R5";
        wr(0, 8'h80);
        rd_expect(0, "R5", 8'h04);
        cur_tag = "R6";
        wr(0, 8'hA2);
        rd_expect(0, "R6", 8'h00);
        int_expect("R6", 1'b1);
        ack_pair("R6", 8'h25);
        wr(0, 8'hA5);

        // R10: mask
        cur_tag = "R10";
        irq_in = 8'h00; tick();
        wr(1, 8'h10);
        irq_in = 8'h10; tick(); tick();
        int_expect("R10", 1'b0);
        wr(0, 8'hC0);
        rd_expect(0, "R10", 8'h10);
        rd_expect(1, "R12", 8'h10);
        wr(1, 8'h00);
        int_expect("R10", 1'b1);
        ack_pair("R10", 8'h24);
        wr(0, 8'h80);

        // R7: automatic end-of-interrupt
        cur_tag = "R7";
        wr(0, 8'h02);
        irq_in = 8'h00; tick();
        irq_in = 8'h01; tick(); tick();
        ack_pair("R7", 8'h20);
        wr(0, 8'hC1);
        rd_expect(0, "R7", 8'h00);

        // R8/R9: level trigger and a dropped request
        cur_tag = "R8";
        wr(0, 8'h01);
        irq_in = 8'h40; tick(); tick();
        int_expect("R8", 1'b1);
        irq_in = 8'h00; tick(); tick();
        int_expect("R8", 1'b0);
        cur_tag = "R9";
        irq_in = 8'h40; tick(); tick();
        irq_in = 8'h00; tick();
        ack_pair("R9", 8'h27);
        rd_expect(0, "R9", 8'h00);

        // R11: poll mode
        cur_tag = "R11";
        wr(0, 8'h04);
        irq_in = 8'h08; tick(); tick();
        int_expect("R11", 1'b0);
        wr(0, 8'hC4);
        rd_expect(0, "R11", 8'h83);
        wr(0, 8'hC1);
        rd_expect(0, "R11", 8'h08);
        wr(0, 8'h80);
        wr(0, 8'hC4);
        rd_expect(0, "R11", 8'h00);
        rd_expect(0, "R12", 8'h00);

        // Randomised stretch compared with the model every cycle.
        cur_tag = "R12";
        wr(0, 8'h00);
        for (int k = 0; k < 2000; k++) begin
            int r = $urandom % 16;
            if (r <= 5)       irq_in = 8'($urandom);
            else if (r <= 7)  ack = 1;
            else if (r == 8)  begin wr_en = 1; wr_sel = 0; wr_data = {2'b10, 1'($urandom), 2'b00, 3'($urandom)}; end
            else if (r == 9)  begin wr_en = 1; wr_sel = 1; wr_data = 8'($urandom) & 8'($urandom); end
            else if (r == 10) begin wr_en = 1; wr_sel = 0; wr_data = {5'b00000, ($urandom % 4 == 0), 2'($urandom)}; end
            else if (r == 11) begin wr_en = 1; wr_sel = 0; wr_data = {2'b11, 3'b000, 1'($urandom), 1'b0, 1'($urandom)}; end
            else if (r <= 13) begin rd_en = 1; rd_sel = 1'($urandom); end
            tick();
            ack = 0; wr_en = 0; rd_en = 0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule